// File: doc/BRIEF.md
# Branch Trace Buffer with Repeat Compression

This block keeps a short history of program-flow changes. Each time the core reports a taken branch, the block can record the branch as a pair of 32-bit addresses (where the branch came from and where it went) in a small circular store of 16 slots. Before it records a branch, it filters it. The control register must enable capture, the branch must not come from a hardware loop, and the core's current interrupt priority level must permit capture.

Tight loops would otherwise fill the store with copies of the same branch. Two optional compression levels prevent this. A repeat of the newest or second-newest recorded pair is not stored. Instead, the block sets the low address bit of the matching entry.

When the store is full, the block does one of two things. It either drops the oldest entry to make room, or it refuses the branch and pulses an overflow exception request. Software drains the history newest-first through a data port that needs two reads per entry. A status register tells software how many entries remain.

Top module: `brtrace_top`

## Requirements
- R1: The store holds up to 16 entries. A read of the status register (offset 0x004) returns the number of valid entries, saturated at 16, in bits 4:0, with the upper bits zero.
- R2: The control register is at offset 0x000. Bit 0 is power, bit 1 is enable, bit 2 is overflow-exception mode, bit 3 is single-level compression and bit 4 is two-level compression. A read returns bits 4:0 with the upper bits zero. After reset, control reads 0, the store is empty and the next data-port read returns a destination.
- R3: A branch strobe is recorded only when both the power bit and the enable bit are set.
- R4: A branch whose hardware-loop flag is high is never recorded.
- R5: The priority level is a 4-bit input where lower means more urgent. Branches at level 1 (the reset level) are never recorded. While the overflow-exception mode is set, branches at levels 0 to 3 are not recorded.
- R6: The data port is at offset 0x100. A read of an empty store returns 0 and changes nothing. Otherwise the first read returns the newest entry's destination. The second read returns its source and removes that entry.
- R7: If the store is full and the overflow-exception mode is set, an accepted branch is dropped. `ovf_exc` is then high for exactly the one cycle after the clock edge that sampled the branch.
- R8: If the store is full and the overflow-exception mode is clear, a newly stored branch replaces the oldest entry. The count stays at 16.
- R9: Single-level compression applies when it is enabled and at least one entry is present. A branch whose source and destination equal those of the newest entry, compared with bit 0 ignored, is not stored. Instead, bit 0 of the newest entry's destination is set.
- R10: Two-level compression applies when it is enabled and at least two entries are present. A branch matching the second-newest entry, compared with bit 0 ignored, is not stored. Instead, bit 0 of that entry's source is set. A match on the newest entry under R9 takes priority.
- R11: Writes to the status register and the data port are acknowledged without error and have no effect. An access is an error when its offset is none of the three, or when its size code is not 2 (32-bit). An error access returns 0 in `bus_rdata` and changes no state.
- R12: Every access presented with `bus_valid` is answered by `bus_ack` on the next cycle, with `bus_rdata` and `bus_err`. `bus_ack` is never high otherwise.
- R13: When a data-port read that removes an entry and a branch capture occur in the same cycle, the removal is applied first and the capture second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_size | input | 2 | Access size code, 2 = 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Response strobe, one cycle after bus_valid |
| bus_err | output | 1 | Invalid access, valid with bus_ack |
| br_valid | input | 1 | Branch event strobe |
| br_src | input | 32 | Branch source address |
| br_dst | input | 32 | Branch destination address |
| br_hwloop | input | 1 | Branch was produced by a hardware loop |
| br_level | input | 4 | Current interrupt priority level |
| ovf_exc | output | 1 | Overflow exception request pulse |

## Verification
The bench builds the block with its default of 16 entries and a 12-bit register offset. With that depth, both ways of handling a full store can be reached within a few dozen captures. These are the wrap that overwrites the oldest slot and the refused branch that pulses the exception. The small depth also lets the bench drain the store completely and check the exact newest-first order. The 12-bit offset covers the data port at 0x100, plus an unmapped offset, for the error path.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;

    localparam int PC_W  = 32;
    localparam int LVL_W = 4;
    localparam int REG_W = 32;

    localparam logic [11:0] OFS_CTRL = 12'h000;
    localparam logic [11:0] OFS_STAT = 12'h004;
    localparam logic [11:0] OFS_DATA = 12'h100;
    localparam logic [1:0]  SIZE_WORD = 2'd2;

    localparam logic [LVL_W-1:0] LVL_RESET   = 4'd1;
    localparam logic [LVL_W-1:0] LVL_EXC_TOP = 4'd3;

    typedef struct packed {
        logic cmp2;
        logic cmp1;
        logic ovf_mode;
        logic en;
        logic pwr;
    } ctrl_t;

    typedef struct packed {
        logic [PC_W-1:0] src;
        logic [PC_W-1:0] dst;
    } entry_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } sel_e;

    function automatic logic same_branch(entry_t e, logic [PC_W-1:0] s, logic [PC_W-1:0] d);
        return (e.src[PC_W-1:1] == s[PC_W-1:1]) && (e.dst[PC_W-1:1] == d[PC_W-1:1]);
    endfunction

    function automatic logic level_blocked(logic [LVL_W-1:0] lvl, logic ovf_mode);
        return (lvl == LVL_RESET) || (ovf_mode && (lvl <= LVL_EXC_TOP));
    endfunction

endpackage

// File: rtl/brtrace_filter.sv
module brtrace_filter
    import brtrace_pkg::*;
(
    input  ctrl_t            ctrl,
    input  logic             br_valid,
    input  logic             br_hwloop,
    input  logic [LVL_W-1:0] br_level,
    output logic             cap_req
);
    always_comb begin
        cap_req = br_valid && ctrl.pwr && ctrl.en && !br_hwloop
                  && !level_blocked(br_level, ctrl.ovf_mode);
    end
endmodule

// File: rtl/brtrace_store.sv
module brtrace_store
    import brtrace_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int OCC_W  = PTR_W + 1
)(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             cap_req,
    input  logic [PC_W-1:0]  cap_src,
    input  logic [PC_W-1:0]  cap_dst,
    input  logic             rd_req,
    output logic [OCC_W-1:0] occ,
    output logic [PC_W-1:0]  rd_word,
    output logic             ovf_exc
);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(ENTRIES);

    entry_t           slots [ENTRIES];
    logic [PTR_W-1:0] top_q;
    logic [OCC_W-1:0] occ_q;
    logic             mid_q;

    logic             has_data, do_pop;
    logic [PTR_W-1:0] top_a, idx_new, idx_prev;
    logic [OCC_W-1:0] occ_a;
    logic             full_a, refuse, hit1, hit2, do_store;

    always_comb begin
        has_data = (occ_q != '0);
        do_pop   = rd_req && has_data && mid_q;
        top_a    = do_pop ? top_q - PTR_W'(1) : top_q;
        occ_a    = do_pop ? occ_q - OCC_W'(1) : occ_q;
        idx_new  = top_a - PTR_W'(1);
        idx_prev = top_a - PTR_W'(2);
        full_a   = (occ_a == OCC_FULL);
        refuse   = cap_req && full_a && ctrl.ovf_mode;
        hit1     = cap_req && !refuse && ctrl.cmp1 && (occ_a >= OCC_W'(1))
                   && same_branch(slots[idx_new], cap_src, cap_dst);
        hit2     = cap_req && !refuse && !hit1 && ctrl.cmp2 && (occ_a >= OCC_W'(2))
                   && same_branch(slots[idx_prev], cap_src, cap_dst);
        do_store = cap_req && !refuse && !hit1 && !hit2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q   <= '0;
            occ_q   <= '0;
            mid_q   <= 1'b0;
            ovf_exc <= 1'b0;
        end else begin
            if (rd_req && has_data)
                mid_q <= !mid_q;
            top_q   <= do_store ? top_a + PTR_W'(1) : top_a;
            occ_q   <= (do_store && !full_a) ? occ_a + OCC_W'(1) : occ_a;
            ovf_exc <= refuse;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (do_store) begin
                slots[top_a].src <= cap_src;
                slots[top_a].dst <= cap_dst;
            end else if (hit1) begin
                slots[idx_new].dst[0] <= 1'b1;
            end else if (hit2) begin
                slots[idx_prev].src[0] <= 1'b1;
            end
        end
    end

    always_comb begin
        occ = occ_q;
        if (!has_data)
            rd_word = '0;
        else if (mid_q)
            rd_word = slots[top_q - PTR_W'(1)].src;
        else
            rd_word = slots[top_q - PTR_W'(1)].dst;
    end
endmodule

// File: rtl/brtrace_regif.sv
module brtrace_regif
    import brtrace_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int BUS_AW  = 12,
    localparam int OCC_W  = $clog2(ENTRIES) + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    input  logic [OCC_W-1:0]  occ,
    input  logic [PC_W-1:0]   rd_word,
    output ctrl_t             ctrl,
    output logic              rd_req
);
    localparam int STAT_MAX = 16;
    localparam int CTRL_W   = $bits(ctrl_t);

    sel_e             sel;
    logic             ok;
    logic [REG_W-1:0] rdata_d;
    logic [REG_W-1:0] stat_val;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata[REG_W-1:CTRL_W];

    always_comb begin
        if (bus_addr == BUS_AW'(OFS_CTRL))      sel = SEL_CTRL;
        else if (bus_addr == BUS_AW'(OFS_STAT)) sel = SEL_STAT;
        else if (bus_addr == BUS_AW'(OFS_DATA)) sel = SEL_DATA;
        else                                     sel = SEL_NONE;
        ok     = (sel != SEL_NONE) && (bus_size == SIZE_WORD);
        rd_req = bus_valid && !bus_write && ok && (sel == SEL_DATA);

        if (occ > OCC_W'(STAT_MAX)) stat_val = REG_W'(STAT_MAX);
        else                        stat_val = REG_W'(occ);

        rdata_d = '0;
        if (bus_valid && !bus_write && ok) begin
            case (sel)
                SEL_CTRL: rdata_d = REG_W'(ctrl);
                SEL_STAT: rdata_d = stat_val;
                SEL_DATA: rdata_d = rd_word;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (bus_valid && bus_write && ok && (sel == SEL_CTRL))
                ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            bus_ack   <= bus_valid;
            bus_err   <= bus_valid && !ok;
            bus_rdata <= rdata_d;
        end
    end
endmodule

// File: rtl/brtrace_top.sv
module brtrace_top
    import brtrace_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int BUS_AW  = 12,
    localparam int OCC_W  = $clog2(ENTRIES) + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    input  logic              br_valid,
    input  logic [31:0]       br_src,
    input  logic [31:0]       br_dst,
    input  logic              br_hwloop,
    input  logic [3:0]        br_level,
    output logic              ovf_exc
);
    ctrl_t            ctrl_q;
    logic             rd_req, cap_req;
    logic [OCC_W-1:0] occ;
    logic [PC_W-1:0]  rd_word;

    brtrace_regif #(.ENTRIES(ENTRIES), .BUS_AW(BUS_AW)) u_regif (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err),
        .occ(occ), .rd_word(rd_word), .ctrl(ctrl_q), .rd_req(rd_req)
    );

    brtrace_filter u_filter (
        .ctrl(ctrl_q), .br_valid(br_valid), .br_hwloop(br_hwloop),
        .br_level(br_level), .cap_req(cap_req)
    );

    brtrace_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst), .ctrl(ctrl_q),
        .cap_req(cap_req), .cap_src(br_src), .cap_dst(br_dst),
        .rd_req(rd_req), .occ(occ), .rd_word(rd_word), .ovf_exc(ovf_exc)
    );
endmodule

// File: rtl/brtrace_chk.sv
module brtrace_chk #(
    parameter int ENTRIES = 16,
    localparam int OCC_W  = $clog2(ENTRIES) + 1
)(
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic             bus_ack,
    input logic             bus_err,
    input logic             br_valid,
    input logic             br_hwloop,
    input logic [3:0]       br_level,
    input logic             ovf_exc,
    input logic [4:0]       ctrl_bits,
    input logic [OCC_W-1:0] occ
);
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst) occ <= OCC_W'(ENTRIES));  // R1
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst) (br_valid && !(ctrl_bits[0] && ctrl_bits[1]) && !bus_valid) |=> $stable(occ));  // R3
    AST_LOOP_SKIP: assert property (@(posedge clk) disable iff (rst) (br_valid && br_hwloop && !bus_valid) |=> $stable(occ));  // R4
    AST_RESET_LVL: assert property (@(posedge clk) disable iff (rst) (br_valid && br_level == 4'd1 && !bus_valid) |=> $stable(occ));  // R5
    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (rst) ovf_exc |-> $past(br_valid));  // R7
    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (rst) bus_valid |=> bus_ack);  // R12
    AST_ACK_ONLY: assert property (@(posedge clk) disable iff (rst) !bus_valid |=> !bus_ack);  // R12
    AST_ERR_ACK: assert property (@(posedge clk) disable iff (rst) bus_err |-> bus_ack);  // R11
    AST_OCC_STEP: assert property (@(posedge clk) disable iff (rst) (occ == $past(occ)) || (occ == $past(occ) + OCC_W'(1)) || (occ + OCC_W'(1) == $past(occ)));  // R13
endmodule

bind brtrace_top brtrace_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ack(bus_ack),
    .bus_err(bus_err), .br_valid(br_valid), .br_hwloop(br_hwloop),
    .br_level(br_level), .ovf_exc(ovf_exc), .ctrl_bits(ctrl_q), .occ(occ)
);

// File: tb/sim_brtrace_top.sv
`timescale 1ns/1ps
module sim_brtrace_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_err;
    logic        br_valid = 1'b0, br_hwloop = 1'b0;
    logic [31:0] br_src = '0, br_dst = '0;
    logic [3:0]  br_level = 4'd6;
    logic        ovf_exc;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_d_q [$];
    logic        exp_e_q [$];
    string       tag_q   [$];

    always #10 clk = ~clk;

    brtrace_top u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
        .br_hwloop(br_hwloop), .br_level(br_level), .ovf_exc(ovf_exc)
    );

    function automatic logic [31:0] sa(int i);
        return 32'h1000_0000 + 32'(i) * 32'd16;
    endfunction
    function automatic logic [31:0] da(int i);
        return 32'h2000_0000 + 32'(i) * 32'd16;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected responses as the design acknowledges
    always @(negedge clk) begin
        if (!rst && bus_ack) begin
            if (exp_d_q.size() == 0) begin
                chk("R12 unexpected ack", 32'd1, 32'd0);
            end else begin
                string t;
                logic [31:0] ed;
                logic ee;
                t  = tag_q.pop_front();
                ed = exp_d_q.pop_front();
                ee = exp_e_q.pop_front();
                chk({t, " rdata"}, bus_rdata, ed);
                chk({t, " err"}, {31'd0, bus_err}, {31'd0, ee});
            end
        end
    end

    task automatic acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] exp_d, input logic exp_e,
                       input string tag);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        exp_d_q.push_back(exp_d); exp_e_q.push_back(exp_e); tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp_d, input string tag);
        acc(1'b0, a, 2'd2, 32'd0, exp_d, 1'b0, tag);
    endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        acc(1'b1, a, 2'd2, d, 32'd0, 1'b0, tag);
    endtask

    task automatic cap(input logic [31:0] s, input logic [31:0] d,
                       input logic [3:0] lvl, input logic hw);
        br_valid = 1'b1; br_src = s; br_dst = d; br_level = lvl; br_hwloop = hw;
        @(negedge clk);
        br_valid = 1'b0; br_hwloop = 1'b0;
    endtask

    task automatic cap_rd(input logic [31:0] s, input logic [31:0] d, input logic [31:0] exp_d);
        br_valid = 1'b1; br_src = s; br_dst = d; br_level = 4'd6;
        acc(1'b0, 12'h100, 2'd2, 32'd0, exp_d, 1'b0, "R13 pop then capture");
        br_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(12'h000, 32'd0, "R2 ctrl after reset");
        rd(12'h004, 32'd0, "R1 status after reset");
        rd(12'h100, 32'd0, "R6 empty data read");

        // capture gating
        cap(sa(0), da(0), 4'd6, 1'b0);
        rd(12'h004, 32'd0, "R3 ctrl=0 no capture");
        wr(12'h000, 32'h1, "R3 power only");
        cap(sa(0), da(0), 4'd6, 1'b0);
        rd(12'h004, 32'd0, "R3 power only no capture");
        wr(12'h000, 32'h2, "R3 enable only");
        cap(sa(0), da(0), 4'd6, 1'b0);
        rd(12'h004, 32'd0, "R3 enable only no capture");
        wr(12'h000, 32'hFFFF_FFFF, "R2 write all ones");
        rd(12'h000, 32'h1F, "R2 ctrl readback width");
        wr(12'h000, 32'h3, "R3 power+enable");
        cap(sa(0), da(0), 4'd6, 1'b0);
        rd(12'h004, 32'd1, "R3 captured");

        // loop and level filtering
        cap(sa(9), da(9), 4'd6, 1'b1);
        rd(12'h004, 32'd1, "R4 hwloop ignored");
        cap(sa(9), da(9), 4'd1, 1'b0);
        rd(12'h004, 32'd1, "R5 reset level ignored");
        cap(sa(1), da(1), 4'd3, 1'b0);
        rd(12'h004, 32'd2, "R5 level 3 captured without ovf mode");
        wr(12'h000, 32'h7, "R5 ovf mode");
        cap(sa(9), da(9), 4'd0, 1'b0);
        cap(sa(9), da(9), 4'd3, 1'b0);
        rd(12'h004, 32'd2, "R5 levels 0..3 ignored in ovf mode");
        cap(sa(2), da(2), 4'd4, 1'b0);
        rd(12'h004, 32'd3, "R5 level 4 captured");

        // newest-first readout
        rd(12'h100, da(2), "R6 newest dst");
        rd(12'h100, sa(2), "R6 newest src");
        rd(12'h004, 32'd2, "R6 pop reduces count");
        rd(12'h100, da(1), "R6 dst");
        rd(12'h100, sa(1), "R6 src");
        rd(12'h100, da(0), "R6 dst");
        rd(12'h100, sa(0), "R6 src");
        rd(12'h004, 32'd0, "R6 empty");
        rd(12'h100, 32'd0, "R6 empty read 0");

        // overwrite when full
        wr(12'h000, 32'h3, "R8 overwrite mode");
        for (int i = 0; i < 20; i++) cap(sa(i), da(i), 4'd6, 1'b0);
        chk("R8 no exception in overwrite", {31'd0, ovf_exc}, 32'd0);
        rd(12'h004, 32'd16, "R8 count saturated");
        for (int i = 19; i >= 4; i--) begin
            rd(12'h100, da(i), "R8 wrapped dst");
            rd(12'h100, sa(i), "R8 wrapped src");
        end
        rd(12'h100, 32'd0, "R8 oldest dropped");

        // exception when full
        wr(12'h000, 32'h7, "R7 ovf mode");
        for (int i = 0; i < 16; i++) cap(sa(i), da(i), 4'd6, 1'b0);
        chk("R7 no pulse before full", {31'd0, ovf_exc}, 32'd0);
        cap(sa(16), da(16), 4'd6, 1'b0);
        chk("R7 pulse after refused branch", {31'd0, ovf_exc}, 32'd1);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'd0, ovf_exc}, 32'd0);
        rd(12'h004, 32'd16, "R7 count unchanged");
        for (int i = 15; i >= 0; i--) begin
            rd(12'h100, da(i), "R7 kept dst");
            rd(12'h100, sa(i), "R7 kept src");
        end

        // single-level compression
        wr(12'h000, 32'hB, "R9 cmp1");
        cap(sa(3), da(3), 4'd6, 1'b0);
        cap(sa(3), da(3), 4'd6, 1'b0);
        cap(sa(3), da(3), 4'd6, 1'b0);
        rd(12'h004, 32'd1, "R9 repeats folded");
        rd(12'h100, da(3) | 32'd1, "R9 dst lsb set");
        rd(12'h100, sa(3), "R9 src untouched");

        // two-level compression
        wr(12'h000, 32'h13, "R10 cmp2");
        cap(sa(5), da(5), 4'd6, 1'b0);
        cap(sa(6), da(6), 4'd6, 1'b0);
        cap(sa(5), da(5), 4'd6, 1'b0);
        rd(12'h004, 32'd2, "R10 second-newest folded");
        rd(12'h100, da(6), "R10 newest dst");
        rd(12'h100, sa(6), "R10 newest src");
        rd(12'h100, da(5), "R10 older dst");
        rd(12'h100, sa(5) | 32'd1, "R10 older src lsb set");

        // priority of single-level match
        wr(12'h000, 32'h3, "R10 plain");
        cap(sa(9), da(9), 4'd6, 1'b0);
        cap(sa(9), da(9), 4'd6, 1'b0);
        wr(12'h000, 32'h1B, "R10 both levels");
        cap(sa(9), da(9), 4'd6, 1'b0);
        rd(12'h004, 32'd2, "R10 priority count");
        rd(12'h100, da(9) | 32'd1, "R10 newest dst marked");
        rd(12'h100, sa(9), "R10 newest src");
        rd(12'h100, da(9), "R10 second dst clean");
        rd(12'h100, sa(9), "R10 second src clean");

        // ignored writes and errors
        wr(12'h000, 32'h3, "R11 setup");
        wr(12'h004, 32'h5, "R11 status write");
        rd(12'h004, 32'd0, "R11 status write ignored");
        cap(sa(10), da(10), 4'd6, 1'b0);
        wr(12'h100, 32'hDEAD_BEEF, "R11 data write");
        rd(12'h004, 32'd1, "R11 data write ignored");
        rd(12'h100, da(10), "R11 data after ignored write");
        acc(1'b0, 12'h008, 2'd2, 32'd0, 32'd0, 1'b1, "R11 bad offset");
        acc(1'b0, 12'h100, 2'd1, 32'd0, 32'd0, 1'b1, "R11 bad size no pop");
        acc(1'b1, 12'h000, 2'd0, 32'h1F, 32'd0, 1'b1, "R11 bad size write");
        rd(12'h000, 32'h3, "R11 ctrl unchanged");
        rd(12'h100, sa(10), "R11 toggle unchanged by errors");
        rd(12'h004, 32'd0, "R11 drained");

        // pop and capture in one cycle
        cap(sa(11), da(11), 4'd6, 1'b0);
        rd(12'h100, da(11), "R13 first half");
        cap_rd(sa(12), da(12), sa(11));
        rd(12'h004, 32'd1, "R13 count after pop+capture");
        rd(12'h100, da(12), "R13 new entry dst");
        rd(12'h100, sa(12), "R13 new entry src");
        rd(12'h004, 32'd0, "R13 empty");

        repeat (3) @(negedge clk);
        chk("R12 all responses seen", 32'(exp_d_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule